// File: doc/BRIEF.md
# Aligned Transfer Segment Splitter

This block sits in front of a serial framing engine that can only move data in three shapes: a 2-byte word, a 4-byte word, or a burst made of whole 8-byte words. A client hands it one request: a direction (read or write), a 32-bit start address and a byte count. The splitter cuts that request into the fewest segments it can, with every segment starting on a naturally aligned address. It issues the segments one at a time as opcode, address and length over a valid/ready handshake.

The splitter walks the request with a running address and a remaining-byte count. After each segment is accepted it waits for the framing engine to report that the segment has finished. Only then does it advance the address by the segment length and pick the next command. The choice depends on the low three address bits and on how many bytes are still left. Bursts never exceed a cap of 240 bytes, which is a parameter.

Requests that the engine cannot carry are refused up front: reads need an even address and an even length, and writes need an even address. An odd write length is extended by one byte; the framing engine fills that byte with zero. A request is taken when `req_valid` is high and `busy` is low.

Top module: `xfer_seg_splitter`

## Requirements
- R1: With A = current address mod 8 and N = bytes still to issue, a 2-byte segment is chosen when A is 2 or 6, or when N equals 2.
- R2: When R1 does not apply, a 4-byte segment is chosen when A is 4 or when N is 6 or less.
- R3: When neither R1 nor R2 applies, a burst is issued whose length is N rounded down to a multiple of 8, capped at 240.
- R4: `seg_op` encodes the segment: 0 = 2-byte read, 2 = 4-byte read, 4 = burst read, and a write uses the read code plus one (1, 3, 5), so bit 0 is the direction.
- R5: A read request with an odd address or an odd length raises `req_err` for one cycle, the cycle after acceptance, and issues no segment.
- R6: A write request with an odd address is refused like R5. A write request with an odd length is treated as one byte longer, so the segments cover length+1 bytes.
- R7: The first segment starts at the request address, and each later segment starts where the previous one ended. A new segment is presented only after `seg_done` has been seen for the previous accepted segment. `req_done` pulses for one cycle after the final `seg_done`.
- R8: A request whose length (after padding) is zero pulses `req_done` in the cycle after acceptance, issues no segment and never raises `busy`.
- R9: `busy` is low after reset, rises the cycle after a non-empty valid request is accepted, and stays high until the final `seg_done`. While `busy` is high, `req_valid` is ignored: no error and no change to the segment stream.
- R10: While `seg_valid` is high and `seg_ready` is low, `seg_valid`, `seg_op`, `seg_addr` and `seg_len` hold their values.
- R11: Every segment address is a multiple of the smaller of its length and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Start byte address |
| req_len | input | 16 | Byte count |
| busy | output | 1 | A request is being split |
| req_err | output | 1 | One-cycle pulse: request refused |
| req_done | output | 1 | One-cycle pulse: request finished |
| seg_valid | output | 1 | Segment command presented |
| seg_ready | input | 1 | Framing engine accepts the segment |
| seg_op | output | 3 | Segment opcode |
| seg_addr | output | 32 | Segment start address |
| seg_len | output | 8 | Segment byte count |
| seg_done | input | 1 | Framing engine finished the accepted segment |

## Verification
The embedded assertions check on every cycle that each presented segment is aligned to its own size and fits in the bytes still remaining. They also check that the opcode's direction bit matches the request, that a stalled segment holds steady, that nothing is presented while a segment is in flight, and that error and completion never pulse together. Only the bench scenarios can show that the chosen sequence is the minimal one. These include the 260-byte walk from offset 2, padding of odd writes, refusal of misaligned requests, empty requests, and requests arriving while busy being ignored.

// File: rtl/seg_split_pkg.sv
package seg_split_pkg;

  typedef enum logic [2:0] {
    OP_RD_W2  = 3'd0,
    OP_WR_W2  = 3'd1,
    OP_RD_W4  = 3'd2,
    OP_WR_W4  = 3'd3,
    OP_RD_BST = 3'd4,
    OP_WR_BST = 3'd5
  } seg_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } split_state_e;

endpackage

// File: rtl/seg_req_check.sv
module seg_req_check #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic              bad,
  output logic [LEN_W:0]    eff_len
);

  logic pad;

  always_comb begin
    // Reads need even address and length; writes need an even address only.
    bad     = addr[0] | (~is_write & len[0]);
    pad     = is_write & len[0];
    eff_len = {1'b0, len} + {{LEN_W{1'b0}}, pad};
  end

endmodule

// File: rtl/seg_cmd_select.sv
module seg_cmd_select
  import seg_split_pkg::*;
#(
  parameter int REM_W     = 17,
  parameter int MAX_BURST = 240,
  parameter int SLW       = 8
) (
  input  logic             is_write,
  input  logic [2:0]       align,
  input  logic [REM_W-1:0] remain,
  output logic [2:0]       op,
  output logic [SLW-1:0]   len
);

  localparam logic [REM_W-1:0] CAP      = REM_W'(MAX_BURST);
  localparam logic [REM_W-1:0] WORD_MSK = ~REM_W'(7);

  logic [REM_W-1:0] burst_raw;
  logic [2:0]       base_op;

  always_comb begin
    burst_raw = remain & WORD_MSK;
    if (align == 3'd2 || align == 3'd6 || remain == REM_W'(2)) begin
      base_op = OP_RD_W2;
      len     = SLW'(2);
    end else if (align == 3'd4 || remain <= REM_W'(6)) begin
      base_op = OP_RD_W4;
      len     = SLW'(4);
    end else begin
      base_op = OP_RD_BST;
      len     = (burst_raw > CAP) ? SLW'(MAX_BURST) : burst_raw[SLW-1:0];
    end
    op = base_op + {2'b00, is_write};
  end

endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_split_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REM_W     = 17,
  parameter int SLW       = 8,
  parameter int MAX_BURST = 240
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_bad,
  input  logic [REM_W-1:0]  req_eff_len,
  input  logic              seg_ready,
  input  logic              seg_done,
  input  logic [2:0]        sel_op,
  input  logic [SLW-1:0]    sel_len,
  output logic              wr_q,
  output logic [ADDR_W-1:0] cur_addr_q,
  output logic [REM_W-1:0]  remain_q,
  output logic              seg_valid,
  output logic              busy,
  output logic              err_q,
  output logic              done_q
);

  split_state_e      state_q, state_n;
  logic [ADDR_W-1:0] cur_addr_n;
  logic [REM_W-1:0]  remain_n;
  logic              wr_n, err_n, done_n;
  logic              load_en, step_en;
  logic [REM_W-1:0]  len_ext;

  assign len_ext   = REM_W'(sel_len);
  assign seg_valid = (state_q == ST_ISSUE);
  assign busy      = (state_q != ST_IDLE);

  always_comb begin
    state_n    = state_q;
    err_n      = 1'b0;
    done_n     = 1'b0;
    load_en    = 1'b0;
    step_en    = 1'b0;
    cur_addr_n = cur_addr_q;
    remain_n   = remain_q;
    wr_n       = wr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_bad) begin
            err_n = 1'b1;
          end else if (req_eff_len == '0) begin
            done_n = 1'b1;
          end else begin
            load_en = 1'b1;
            state_n = ST_ISSUE;
          end
        end
      end
      ST_ISSUE: begin
        if (seg_ready) state_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (seg_done) begin
          step_en = 1'b1;
          if (remain_q == len_ext) begin
            state_n = ST_IDLE;
            done_n  = 1'b1;
          end else begin
            state_n = ST_ISSUE;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
    if (load_en) begin
      cur_addr_n = req_addr;
      remain_n   = req_eff_len;
      wr_n       = req_write;
    end else if (step_en) begin
      cur_addr_n = cur_addr_q + ADDR_W'(sel_len);
      remain_n   = remain_q - len_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      cur_addr_q <= '0;
      remain_q   <= '0;
      wr_q       <= 1'b0;
    end else begin
      state_q <= state_n;
      err_q   <= err_n;
      done_q  <= done_n;
      if (load_en || step_en) begin
        cur_addr_q <= cur_addr_n;
        remain_q   <= remain_n;
        wr_q       <= wr_n;
      end
    end
  end

  assert_seg_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> ((sel_len == SLW'(2)) ? (cur_addr_q[0] == 1'b0) :
                   (sel_len == SLW'(4)) ? (cur_addr_q[1:0] == 2'b00) :
                                          (cur_addr_q[2:0] == 3'b000)));

  assert_len_fits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (len_ext <= remain_q) && (sel_len != '0) &&
                  (sel_len <= SLW'(MAX_BURST)));

  assert_op_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (sel_op[0] == wr_q) && (sel_op <= 3'd5));

  assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(cur_addr_q) &&
                                $stable(sel_op) && $stable(sel_len));

  assert_wait_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) && !seg_done |=> !seg_valid);

  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !busy && !seg_valid && !done_q);

endmodule

// File: rtl/xfer_seg_splitter.sv
module xfer_seg_splitter
  import seg_split_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 240,
  parameter int SLW       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              req_err,
  output logic              req_done,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [2:0]        seg_op,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [SLW-1:0]    seg_len,
  input  logic              seg_done
);

  localparam int REM_W = LEN_W + 1;

  logic              bad;
  logic [REM_W-1:0]  eff_len;
  logic              wr_q;
  logic [ADDR_W-1:0] cur_addr_q;
  logic [REM_W-1:0]  remain_q;
  logic [2:0]        sel_op;
  logic [SLW-1:0]    sel_len;

  seg_req_check #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_check (
    .is_write (req_write),
    .addr     (req_addr),
    .len      (req_len),
    .bad      (bad),
    .eff_len  (eff_len)
  );

  seg_cmd_select #(.REM_W(REM_W), .MAX_BURST(MAX_BURST), .SLW(SLW)) u_select (
    .is_write (wr_q),
    .align    (cur_addr_q[2:0]),
    .remain   (remain_q),
    .op       (sel_op),
    .len      (sel_len)
  );

  seg_ctrl #(.ADDR_W(ADDR_W), .REM_W(REM_W), .SLW(SLW), .MAX_BURST(MAX_BURST)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_bad     (bad),
    .req_eff_len (eff_len),
    .seg_ready   (seg_ready),
    .seg_done    (seg_done),
    .sel_op      (sel_op),
    .sel_len     (sel_len),
    .wr_q        (wr_q),
    .cur_addr_q  (cur_addr_q),
    .remain_q    (remain_q),
    .seg_valid   (seg_valid),
    .busy        (busy),
    .err_q       (req_err),
    .done_q      (req_done)
  );

  assign seg_op   = sel_op;
  assign seg_addr = cur_addr_q;
  assign seg_len  = sel_len;

endmodule

// File: tb/xfer_seg_splitter_tb_top.sv
module xfer_seg_splitter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr;
  logic [15:0] req_len;
  logic        busy, req_err, req_done, seg_valid, seg_ready, seg_done;
  logic [2:0]  seg_op;
  logic [31:0] seg_addr;
  logic [7:0]  seg_len;

  int checks = 0;
  int fails  = 0;
  int nseg;
  int got_len [64];
  logic [31:0] got_addr [64];

  always #5 clk = ~clk;

  xfer_seg_splitter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .req_err(req_err),
    .req_done(req_done), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_op(seg_op), .seg_addr(seg_addr), .seg_len(seg_len), .seg_done(seg_done)
  );

  // {write, addr, len, stall}
  localparam int NV = 14;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 32'h0000_1000, 16'd8,   1'b0},
    {1'b0, 32'h0000_1000, 16'd4,   1'b1},
    {1'b0, 32'h0000_1002, 16'd2,   1'b0},
    {1'b0, 32'h0000_1006, 16'd10,  1'b1},
    {1'b1, 32'h0000_2004, 16'd7,   1'b0},
    {1'b1, 32'h0000_2000, 16'd500, 1'b1},
    {1'b0, 32'h0000_3001, 16'd4,   1'b0},
    {1'b0, 32'h0000_3000, 16'd3,   1'b0},
    {1'b1, 32'h0000_3003, 16'd4,   1'b0},
    {1'b1, 32'h0000_4000, 16'd0,   1'b0},
    {1'b0, 32'h0000_4000, 16'd0,   1'b0},
    {1'b1, 32'h0000_4000, 16'd1,   1'b1},
    {1'b0, 32'h0000_5000, 16'd6,   1'b0},
    {1'b1, 32'h0000_600A, 16'd30,  1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void pick(input logic [31:0] a, input int rem, input bit w,
                               output int len, output int op);
    int al;
    al = int'(a[2:0]);
    if (al == 2 || al == 6 || rem == 2) begin len = 2; op = 0; end
    else if (al == 4 || rem <= 6) begin len = 4; op = 2; end
    else begin
      len = (rem / 8) * 8;
      if (len > 240) len = 240;
      op = 4;
    end
    op = op + int'(w);
  endfunction

  task automatic run_req(input bit w, input logic [31:0] a, input int len, input bit stall);
    bit bad;
    int rem, plen, pop;
    logic [31:0] cur;
    nseg = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_len = 16'(len);
    @(negedge clk);
    req_valid = 1'b0;
    bad = a[0] || (!w && (len % 2 == 1));
    rem = len + ((w && (len % 2 == 1)) ? 1 : 0);
    if (bad) begin
      chk(w ? "R6 err" : "R5 err", {31'd0, req_err}, 32'd1);
      chk("R5 no seg", {31'd0, seg_valid}, 32'd0);
      chk("R5 busy", {31'd0, busy}, 32'd0);
      @(negedge clk);
      chk("R5 no seg later", {31'd0, seg_valid}, 32'd0);
      return;
    end
    if (rem == 0) begin
      chk("R8 done", {31'd0, req_done}, 32'd1);
      chk("R8 busy", {31'd0, busy}, 32'd0);
      chk("R8 no seg", {31'd0, seg_valid}, 32'd0);
      return;
    end
    chk("R9 busy", {31'd0, busy}, 32'd1);
    cur = a;
    while (rem > 0) begin
      pick(cur, rem, w, plen, pop);
      chk("R7 valid", {31'd0, seg_valid}, 32'd1);
      chk(plen == 2 ? "R1 len" : plen == 4 ? "R2 len" : "R3 len",
          {24'd0, seg_len}, 32'(plen));
      chk("R4 op", {29'd0, seg_op}, 32'(pop));
      chk("R7 R11 addr", seg_addr, cur);
      if (nseg < 64) begin got_len[nseg] = int'(seg_len); got_addr[nseg] = seg_addr; end
      nseg++;
      if (stall) begin
        @(negedge clk);
        chk("R10 held valid", {31'd0, seg_valid}, 32'd1);
        chk("R10 held addr", seg_addr, cur);
        chk("R10 held len", {24'd0, seg_len}, 32'(plen));
      end
      seg_ready = 1'b1;
      @(negedge clk);
      seg_ready = 1'b0;
      chk("R7 wait", {31'd0, seg_valid}, 32'd0);
      if (stall) begin
        req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_7001; req_len = 16'd2;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 ignore err", {31'd0, req_err}, 32'd0);
        chk("R9 still busy", {31'd0, busy}, 32'd1);
        chk("R7 still wait", {31'd0, seg_valid}, 32'd0);
      end
      seg_done = 1'b1;
      @(negedge clk);
      seg_done = 1'b0;
      cur = cur + 32'(plen);
      rem = rem - plen;
      if (rem == 0) begin
        chk("R7 done", {31'd0, req_done}, 32'd1);
        chk("R9 idle", {31'd0, busy}, 32'd0);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_len = '0;
    seg_ready = 1'b0; seg_done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset busy", {31'd0, busy}, 32'd0);
    chk("R7 reset valid", {31'd0, seg_valid}, 32'd0);
    chk("R5 reset err", {31'd0, req_err}, 32'd0);
    chk("R8 reset done", {31'd0, req_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_req(VEC[i][49], VEC[i][48:17], int'(VEC[i][16:1]), VEC[i][0]);

    // 260-byte read from an address two bytes past an 8-byte boundary
    run_req(1'b0, 32'h6003_0002, 260, 1'b0);
    chk("R3 count", 32'(nseg), 32'd6);
    chk("R1 s0 len", 32'(got_len[0]), 32'd2);
    chk("R2 s1 len", 32'(got_len[1]), 32'd4);
    chk("R3 s2 len", 32'(got_len[2]), 32'd240);
    chk("R3 s3 len", 32'(got_len[3]), 32'd8);
    chk("R2 s4 len", 32'(got_len[4]), 32'd4);
    chk("R1 s5 len", 32'(got_len[5]), 32'd2);
    chk("R7 s3 addr", got_addr[3], 32'h6003_00F8);
    chk("R7 s5 addr", got_addr[5], 32'h6003_0104);

    // odd write length padded: 5 bytes at 0x...08 become 4 + 2
    run_req(1'b1, 32'h0000_8008, 5, 1'b0);
    chk("R6 pad count", 32'(nseg), 32'd2);
    chk("R6 pad last", 32'(got_len[1]), 32'd2);

    // reset in the middle of a transfer
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_9000; req_len = 16'd64;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy before reset", {31'd0, busy}, 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset mid busy", {31'd0, busy}, 32'd0);
    chk("R7 reset mid valid", {31'd0, seg_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule